// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command, address, bank and clock-enable pins of a single-data-rate SDRAM. It starts at reset and stops once the device can take normal traffic. Out of reset it holds clock-enable low and places only no-operation commands on the bus. During a programmable power-up wait it raises clock-enable. When the wait ends it closes every bank with one precharge-all command and waits the row-precharge time. It then runs a configurable number of auto-refresh commands, each followed by the refresh cycle time. Last, it writes the mode register and waits the mode-register delay. After that it raises a done flag, and the flag stays high until the next reset.

All waits are parameters counted in clock cycles. Each wait counter is loaded on the same edge that puts the command which starts the wait onto the pins. The mode word comes from configuration inputs: burst length, burst ordering, CAS latency, operating mode and write-burst behaviour. The block samples these inputs on the edge that issues the mode-register load, and ignores them on every other edge. Every output is a register, so the pins change only on clock edges.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `sdr_cke` is 0, the command is NOP, `init_done` is 0, and `sdr_addr` and `sdr_ba` are 0. A reset at any point restarts the sequence from the beginning. The command is the vector {cs_n, ras_n, cas_n, we_n}; NOP is 0111.
- R2: Counting the first cycle after reset release as cycle 0, cycles 0 to T_PWRUP-1 carry NOP. Cycle T_PWRUP carries PRECHARGE (0010) with address bit 10 set, which selects all banks.
- R3: `sdr_cke` is 0 for cycles 0 to CKE_RISE-1. It is 1 from cycle CKE_RISE onward and does not fall again until a reset.
- R4: The first AUTO REFRESH (0001) appears exactly T_RP cycles after the PRECHARGE, with only NOP between them.
- R5: Exactly N_REFRESH AUTO REFRESH commands are issued, each T_RFC cycles after the previous one, with only NOP between them. Every non-NOP command lasts one cycle.
- R6: LOAD MODE (0000) appears exactly T_RFC cycles after the last AUTO REFRESH, and the bank pins read 00 at that point. The bank pins stay 00 throughout the sequence.
- R7: During LOAD MODE the address carries the mode word: bits 2:0 are the burst length, bit 3 the burst ordering (0 sequential, 1 interleaved), bits 6:4 the CAS latency, bits 8:7 the operating mode, bit 9 the write-burst mode, and every bit above 9 is 0. On all other cycles the address is 0, except bit 10 during PRECHARGE.
- R8: `init_done` stays 0 until exactly T_MRD cycles after LOAD MODE, with only NOP in between. It rises on that cycle.
- R9: Once `init_done` is 1 it stays 1, the command stays NOP, `sdr_cke` stays 1 and the address stays 0 until the next reset, whatever the configuration inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_burst_len | input | 3 | Burst length field of the mode word |
| cfg_burst_ilv | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 3 | CAS latency field of the mode word |
| cfg_op_mode | input | 2 | Operating mode field of the mode word |
| cfg_wr_single | input | 1 | Write-burst mode bit of the mode word |
| sdr_cke | output | 1 | Clock enable to the memory |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_addr | output | ADDR_W | Address pins; carry the mode word and the all-bank flag |
| sdr_ba | output | BA_W | Bank address pins |
| init_done | output | 1 | High once the device is ready, until reset |

## Verification
The assertions take for granted two things about the parameters: CKE_RISE lies strictly inside the power-up wait, and every wait is at least one cycle. Given that, the pins never see a non-NOP command while clock-enable is low, and no command lasts more than one cycle. The assertions assume nothing about the configuration inputs, because the only inputs that shape the pins are reset and the five mode fields. The stimulus keeps the configuration stable from reset release through the mode-register load and draws it at random per run. After the done flag rises, the stimulus scrambles the configuration every cycle to show that it has no effect. One run is cut short by a reset in the middle of the sequence, at a random cycle, to show that the sequence restarts.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // command vector ordering: {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_TRP,
    ST_TRFC,
    ST_TMRD,
    ST_READY
  } seq_state_e;

  localparam int ALL_BANK_BIT = 10;
  localparam int MODE_BITS    = 10;

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= RST_VAL;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign expired = (cnt_q == '0);

  // R4: an expired timer that is not reloaded keeps reporting expiry
  a_r4_timer_holds_zero: assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> expired);

endmodule

// File: rtl/mode_word_pack.sv
module mode_word_pack #(
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        burst_len,
  input  logic              burst_ilv,
  input  logic [2:0]        cas_lat,
  input  logic [1:0]        op_mode,
  input  logic              wr_single,
  output logic [ADDR_W-1:0] word
);

  import sdram_init_pkg::*;

  logic [MODE_BITS-1:0] fields;

  assign fields = {wr_single, op_mode, cas_lat, burst_ilv, burst_len};

  generate
    if (ADDR_W > MODE_BITS) begin : g_pad
      assign word = {{(ADDR_W-MODE_BITS){1'b0}}, fields};
    end else begin : g_exact
      assign word = fields[ADDR_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq #(
  parameter int T_PWRUP   = 20000,
  parameter int CKE_RISE  = 10000,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 14,
  parameter int T_MRD     = 2,
  parameter int N_REFRESH = 2,
  parameter int ADDR_W    = 12,
  parameter int BA_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_ilv,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [1:0]        cfg_op_mode,
  input  logic              cfg_wr_single,
  output logic              sdr_cke,
  output logic              sdr_cs_n,
  output logic              sdr_ras_n,
  output logic              sdr_cas_n,
  output logic              sdr_we_n,
  output logic [ADDR_W-1:0] sdr_addr,
  output logic [BA_W-1:0]   sdr_ba,
  output logic              init_done
);

  import sdram_init_pkg::*;

  localparam int MAX_A    = (T_PWRUP > T_RFC) ? T_PWRUP : T_RFC;
  localparam int MAX_B    = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int REF_W    = $clog2(N_REFRESH + 1);

  localparam logic [CNT_W-1:0] LD_PWRUP = CNT_W'(T_PWRUP - 1);
  localparam logic [CNT_W-1:0] LD_RP    = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_RFC   = CNT_W'(T_RFC - 1);
  localparam logic [CNT_W-1:0] LD_MRD   = CNT_W'(T_MRD - 1);
  localparam logic [CNT_W-1:0] CKE_AT   = CNT_W'(T_PWRUP - CKE_RISE);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(N_REFRESH);

  seq_state_e        state_q;
  sdr_cmd_e          cmd_q;
  logic              cke_q;
  logic              done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BA_W-1:0]   ba_q;
  logic [REF_W-1:0]  ref_cnt_q;

  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_load_val;
  logic [CNT_W-1:0]  tmr_cnt;
  logic              tmr_expired;
  logic [ADDR_W-1:0] mode_word;
  logic              last_ref;

  init_wait_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (LD_PWRUP)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_load_val),
    .cnt_o    (tmr_cnt),
    .expired  (tmr_expired)
  );

  mode_word_pack #(
    .ADDR_W (ADDR_W)
  ) u_mode (
    .burst_len (cfg_burst_len),
    .burst_ilv (cfg_burst_ilv),
    .cas_lat   (cfg_cas_lat),
    .op_mode   (cfg_op_mode),
    .wr_single (cfg_wr_single),
    .word      (mode_word)
  );

  assign last_ref = (ref_cnt_q == REF_LAST);

  // the wait that follows a command is armed on the edge that issues it
  always_comb begin
    tmr_load     = 1'b0;
    tmr_load_val = '0;
    if (tmr_expired) begin
      unique case (state_q)
        ST_PWRUP: begin tmr_load = 1'b1; tmr_load_val = LD_RP;  end
        ST_TRP:   begin tmr_load = 1'b1; tmr_load_val = LD_RFC; end
        ST_TRFC:  begin
          tmr_load     = 1'b1;
          tmr_load_val = last_ref ? LD_MRD : LD_RFC;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_PWRUP;
      cmd_q     <= CMD_NOP;
      cke_q     <= 1'b0;
      done_q    <= 1'b0;
      addr_q    <= '0;
      ba_q      <= '0;
      ref_cnt_q <= '0;
    end else begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      unique case (state_q)
        ST_PWRUP: begin
          if (tmr_cnt <= CKE_AT)
            cke_q <= 1'b1;
          if (tmr_expired) begin
            cmd_q                <= CMD_PRE;
            addr_q[ALL_BANK_BIT] <= 1'b1;
            state_q              <= ST_TRP;
          end
        end
        ST_TRP: begin
          if (tmr_expired) begin
            cmd_q     <= CMD_REF;
            ref_cnt_q <= ref_cnt_q + 1'b1;
            state_q   <= ST_TRFC;
          end
        end
        ST_TRFC: begin
          if (tmr_expired) begin
            if (last_ref) begin
              cmd_q   <= CMD_LMR;
              addr_q  <= mode_word;
              state_q <= ST_TMRD;
            end else begin
              cmd_q     <= CMD_REF;
              ref_cnt_q <= ref_cnt_q + 1'b1;
            end
          end
        end
        ST_TMRD: begin
          if (tmr_expired) begin
            done_q  <= 1'b1;
            state_q <= ST_READY;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdr_cke   = cke_q;
  assign sdr_cs_n  = cmd_q[3];
  assign sdr_ras_n = cmd_q[2];
  assign sdr_cas_n = cmd_q[1];
  assign sdr_we_n  = cmd_q[0];
  assign sdr_addr  = addr_q;
  assign sdr_ba    = ba_q;
  assign init_done = done_q;

  // R5: every real command is a single cycle followed by NOP
  a_r5_one_cycle_cmd: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP));

  // R3: clock enable never drops outside reset
  a_r3_cke_no_fall: assert property (@(posedge clk) disable iff (rst)
    !$fell(cke_q));

  // R1: no real command while clock enable is low
  a_r1_cmd_needs_cke: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP) |-> cke_q);

  // R2: precharge always targets every bank
  a_r2_pre_all_banks: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |-> addr_q[ALL_BANK_BIT]);

  // R6: mode load goes to bank 0 and precedes done
  a_r6_lmr_bank_zero: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_LMR) |-> (ba_q == '0 && !done_q));

  // R9: done is sticky
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);

  // R9: bus is quiet and clock enabled once done
  a_r9_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (cmd_q == CMD_NOP && addr_q == '0 && cke_q));

  // R8: done only rises after the mode load has left the pins
  a_r8_done_after_lmr: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> (state_q == ST_READY && ref_cnt_q == REF_LAST));

endmodule

// File: tb/tb_sdram_pwrup_seq.sv
`timescale 1ns/1ps
module tb_sdram_pwrup_seq;

  localparam int T_PWRUP   = 40;
  localparam int CKE_RISE  = 11;
  localparam int T_RP      = 3;
  localparam int T_RFC     = 7;
  localparam int T_MRD     = 2;
  localparam int N_REFRESH = 3;
  localparam int ADDR_W    = 12;
  localparam int BA_W      = 2;

  localparam int K_PRE  = T_PWRUP;
  localparam int K_REF0 = K_PRE + T_RP;
  localparam int K_LMR  = K_REF0 + N_REFRESH * T_RFC;
  localparam int K_DONE = K_LMR + T_MRD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg_burst_len = '0;
  logic       cfg_burst_ilv = 1'b0;
  logic [2:0] cfg_cas_lat = '0;
  logic [1:0] cfg_op_mode = '0;
  logic       cfg_wr_single = 1'b0;
  logic sdr_cke, sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n, init_done;
  logic [ADDR_W-1:0] sdr_addr;
  logic [BA_W-1:0]   sdr_ba;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sdram_pwrup_seq #(
    .T_PWRUP(T_PWRUP), .CKE_RISE(CKE_RISE), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .N_REFRESH(N_REFRESH), .ADDR_W(ADDR_W), .BA_W(BA_W)
  ) dut (
    .clk(clk), .rst(rst),
    .cfg_burst_len(cfg_burst_len), .cfg_burst_ilv(cfg_burst_ilv),
    .cfg_cas_lat(cfg_cas_lat), .cfg_op_mode(cfg_op_mode),
    .cfg_wr_single(cfg_wr_single),
    .sdr_cke(sdr_cke), .sdr_cs_n(sdr_cs_n), .sdr_ras_n(sdr_ras_n),
    .sdr_cas_n(sdr_cas_n), .sdr_we_n(sdr_we_n), .sdr_addr(sdr_addr),
    .sdr_ba(sdr_ba), .init_done(init_done)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_cmd(int k);
    if (k == K_PRE) return 4'b0010;
    if (k == K_LMR) return 4'b0000;
    for (int i = 0; i < N_REFRESH; i++)
      if (k == K_REF0 + i * T_RFC) return 4'b0001;
    return 4'b0111;
  endfunction

  function automatic string cmd_req(int k);
    if (k <= K_PRE)  return "R2";
    if (k <= K_REF0) return "R4";
    if (k < K_LMR)   return "R5";
    if (k == K_LMR)  return "R6";
    if (k < K_DONE)  return "R8";
    return "R9";
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(int k, logic [9:0] mw);
    if (k == K_PRE) return ADDR_W'(1) << 10;
    if (k == K_LMR) return ADDR_W'(mw);
    return '0;
  endfunction

  function automatic logic [9:0] cur_mode();
    return {cfg_wr_single, cfg_op_mode, cfg_cas_lat, cfg_burst_ilv, cfg_burst_len};
  endfunction

  task automatic set_cfg(logic [9:0] v);
    {cfg_wr_single, cfg_op_mode, cfg_cas_lat, cfg_burst_ilv, cfg_burst_len} = v;
  endtask

  task automatic do_reset(int cycles);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk("R1", "cke in reset", 32'(sdr_cke), 32'd0);
      chk("R1", "cmd in reset", 32'({sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n}), 32'h7);
      chk("R1", "done in reset", 32'(init_done), 32'd0);
      chk("R1", "addr/ba in reset", 32'({sdr_ba, sdr_addr}), 32'd0);
    end
    rst = 1'b0;
  endtask

  // runs from reset release; stops early at abort_at when abort_at >= 0
  task automatic run_trial(logic [9:0] mw, int abort_at);
    int last_k;
    last_k = (abort_at >= 0) ? abort_at : K_DONE + 6;
    set_cfg(mw);
    for (int k = 0; k <= last_k; k++) begin
      if (k > 0) @(negedge clk);
      chk(cmd_req(k), "cmd", 32'({sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n}), 32'(exp_cmd(k)));
      chk((k < CKE_RISE) ? "R1" : "R3", "cke", 32'(sdr_cke), 32'(k >= CKE_RISE));
      chk((k < K_DONE) ? "R8" : "R9", "done", 32'(init_done), 32'(k >= K_DONE));
      chk((k > K_LMR) ? "R9" : "R7", "addr", 32'(sdr_addr), 32'(exp_addr(k, mw)));
      chk("R6", "ba", 32'(sdr_ba), 32'd0);
      if (k >= K_LMR) set_cfg(10'($urandom));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: held reset from time zero
    do_reset(3);
    run_trial(10'h000, -1);
    do_reset(2);
    run_trial(10'h3FF, -1);
    // R1: restart after a reset part way through the refresh loops
    do_reset(2);
    run_trial(10'h155, K_REF0 + T_RFC + 2);
    do_reset(3);
    run_trial(10'h2AA, -1);
    // R1: random abort point anywhere in the sequence
    do_reset(2);
    run_trial(10'($urandom), 1 + int'($urandom_range(K_DONE)));
    for (int t = 0; t < 6; t++) begin
      do_reset(2 + int'($urandom_range(3)));
      run_trial(10'($urandom), -1);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule